// File: doc/BRIEF.md
# Interrupt Status Aggregator for a Four-Machine Programmable I/O Engine

This block gathers every interrupt source of a programmable I/O engine into one 12-bit raw vector and drives two interrupt lines from it. Eight of the sources are levels that come straight from the machines' FIFOs: one receive-not-empty bit and one transmit-not-full bit per machine. The other four come from an eight-entry bank of sticky event flags. Any machine can set any of these flags, and the machines can see all eight. Only the lower four reach the raw vector.

Software reaches the block through a write-only register port. One address clears flags with a write-one-to-clear mask. Another address sets flags, and the machines observe the result. Each interrupt line has its own enable register and its own force register. The masked status of line k is (raw AND enable_k) OR force_k. The line is the OR of that status, registered for one cycle. Forcing a line changes neither the flags nor the raw vector.

Register addresses are 0 for flag clear and 1 for flag set. Line k uses address 2+2k for its enable and 3+2k for its force. A write takes effect at the clock edge that samples it.

Top module: `irq_agg_ctrl`

## Requirements
- R1: raw_o[3:0] = rx_not_empty_i[3:0], raw_o[7:4] = tx_not_full_i[3:0], raw_o[11:8] = flags_o[3:0].
- R2: Eight flags are stored and shown on flags_o. Flags 4 to 7 never appear in raw_o or in either masked status.
- R3: A 1 on sm_set_i[n] sets flag n at the next edge. The flag stays set until it is cleared.
- R4: A write to address 0 clears each flag whose wr_data_i[7:0] bit is 1. It leaves flags whose bit is 0 unchanged.
- R5: A write to address 1 sets each flag whose wr_data_i[7:0] bit is 1, and the result shows on flags_o.
- R6: When a clear and a set of the same flag fall in the same cycle, the flag ends up set.
- R7: A write to address 2+2k loads enable_k from wr_data_i[11:0]. masked_o[12k+11:12k] = (raw_o AND enable_k) OR force_k.
- R8: A write to address 3+2k loads force_k from wr_data_i[11:0]. Such a write does not change flags_o or raw_o.
- R9: Bits 7:0 of raw_o follow the FIFO inputs as levels. A flag-clear write whose data has all bits set does not change them.
- R10: irq_o[k] equals the OR of masked status k as it stood one cycle earlier.
- R11: While rst_ni is low, all flags, enables and forces are zero and irq_o is 0.
- R12: Writes to the registers of one line leave the masked status of the other line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_not_empty_i | input | 4 | Receive FIFO not-empty level per machine |
| tx_not_full_i | input | 4 | Transmit FIFO not-full level per machine |
| sm_set_i | input | 8 | Flag set requests from the machines, already ORed together |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 12 | Register write data |
| flags_o | output | 8 | Flag state as the machines see it |
| raw_o | output | 12 | Raw status vector |
| masked_o | output | 24 | Masked status; line k occupies bits 12k+11:12k |
| irq_o | output | 2 | Registered interrupt lines |

## Verification
The bench clears and sets the same flag in one cycle. A design that let the clear win would drop a machine's event and show flag 2 low. The bench sets only flags 4 to 7. A design that wired the wrong half of the bank into the raw vector would light bits 11:8 and raise a line. The bench writes all ones to the clear register while the FIFO levels are high. Hardware that applied the mask to the level bits would lose receive and transmit status. It also checks that the line lags its masked status by exactly one cycle, that forcing one line leaves the flags and the other line alone, and that reset in the middle of a run returns everything to zero.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int SM_CNT    = 4;
  localparam int FLAG_CNT  = 8;
  localparam int VIS_CNT   = 4;
  localparam int LINE_CNT  = 2;

  localparam int ADDR_CLR  = 0;
  localparam int ADDR_SET  = 1;

  function automatic int en_addr(input int line);
    return 2 + 2 * line;
  endfunction

  function automatic int frc_addr(input int line);
    return 3 + 2 * line;
  endfunction
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int NUM_FLAGS = 8,
  parameter int ADDR_W    = 3,
  parameter int CLR_ADDR  = 0,
  parameter int SET_ADDR  = 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_FLAGS-1:0] sm_set_i,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    wr_addr_i,
  input  logic [NUM_FLAGS-1:0] wr_data_i,
  output logic [NUM_FLAGS-1:0] flags_o
);
  localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(CLR_ADDR);
  localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(SET_ADDR);

  logic [NUM_FLAGS-1:0] flags_q, flags_d, clr_mask, set_mask;

  always_comb begin
    clr_mask = (wr_en_i && wr_addr_i == CLR_A) ? wr_data_i : '0;
    set_mask = (wr_en_i && wr_addr_i == SET_A) ? wr_data_i : '0;
    // set terms applied after clear: set wins
    flags_d  = (flags_q & ~clr_mask) | sm_set_i | set_mask;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= flags_d;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/irq_raw_merge.sv
module irq_raw_merge #(
  parameter int NUM_SM  = 4,
  parameter int NUM_VIS = 4,
  localparam int RAW_W  = 2 * NUM_SM + NUM_VIS
) (
  input  logic [NUM_SM-1:0]  rx_not_empty_i,
  input  logic [NUM_SM-1:0]  tx_not_full_i,
  input  logic [NUM_VIS-1:0] vis_flags_i,
  output logic [RAW_W-1:0]   raw_o
);
  assign raw_o = {vis_flags_i, tx_not_full_i, rx_not_empty_i};
endmodule

// File: rtl/irq_out_ctrl.sv
module irq_out_ctrl #(
  parameter int RAW_W    = 12,
  parameter int ADDR_W   = 3,
  parameter int EN_ADDR  = 2,
  parameter int FRC_ADDR = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [RAW_W-1:0]  wr_data_i,
  input  logic [RAW_W-1:0]  raw_i,
  output logic [RAW_W-1:0]  masked_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] EN_A  = ADDR_W'(EN_ADDR);
  localparam logic [ADDR_W-1:0] FRC_A = ADDR_W'(FRC_ADDR);

  logic [RAW_W-1:0] en_q, frc_q;
  logic             irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      frc_q <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == EN_A)  en_q  <= wr_data_i;
      if (wr_addr_i == FRC_A) frc_q <= wr_data_i;
    end
  end

  assign masked_o = (raw_i & en_q) | frc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |masked_o;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
#(
  parameter int NUM_SM    = SM_CNT,
  parameter int NUM_FLAGS = FLAG_CNT,
  parameter int NUM_VIS   = VIS_CNT,
  parameter int NUM_OUT   = LINE_CNT,
  localparam int RAW_W    = 2 * NUM_SM + NUM_VIS,
  localparam int ADDR_W   = $clog2(2 + 2 * NUM_OUT)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_SM-1:0]        rx_not_empty_i,
  input  logic [NUM_SM-1:0]        tx_not_full_i,
  input  logic [NUM_FLAGS-1:0]     sm_set_i,
  input  logic                     wr_en_i,
  input  logic [ADDR_W-1:0]        wr_addr_i,
  input  logic [RAW_W-1:0]         wr_data_i,
  output logic [NUM_FLAGS-1:0]     flags_o,
  output logic [RAW_W-1:0]         raw_o,
  output logic [NUM_OUT*RAW_W-1:0] masked_o,
  output logic [NUM_OUT-1:0]       irq_o
);
  logic [NUM_FLAGS-1:0] flags;
  logic [RAW_W-1:0]     raw;

  irq_flag_bank #(
    .NUM_FLAGS(NUM_FLAGS),
    .ADDR_W   (ADDR_W),
    .CLR_ADDR (ADDR_CLR),
    .SET_ADDR (ADDR_SET)
  ) u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sm_set_i (sm_set_i),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i[NUM_FLAGS-1:0]),
    .flags_o  (flags)
  );

  irq_raw_merge #(
    .NUM_SM (NUM_SM),
    .NUM_VIS(NUM_VIS)
  ) u_raw (
    .rx_not_empty_i(rx_not_empty_i),
    .tx_not_full_i (tx_not_full_i),
    .vis_flags_i   (flags[NUM_VIS-1:0]),
    .raw_o         (raw)
  );

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_line
    irq_out_ctrl #(
      .RAW_W   (RAW_W),
      .ADDR_W  (ADDR_W),
      .EN_ADDR (en_addr(k)),
      .FRC_ADDR(frc_addr(k))
    ) u_line (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_en_i  (wr_en_i),
      .wr_addr_i(wr_addr_i),
      .wr_data_i(wr_data_i),
      .raw_i    (raw),
      .masked_o (masked_o[k*RAW_W +: RAW_W]),
      .irq_o    (irq_o[k])
    );
  end

  assign flags_o = flags;
  assign raw_o   = raw;
endmodule

// File: rtl/irq_agg_checker.sv
module irq_agg_checker #(
  parameter int NUM_SM    = 4,
  parameter int NUM_FLAGS = 8,
  parameter int NUM_VIS   = 4,
  parameter int NUM_OUT   = 2,
  parameter int RAW_W     = 12,
  parameter int ADDR_W    = 3
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [NUM_SM-1:0]        rx_not_empty_i,
  input logic [NUM_SM-1:0]        tx_not_full_i,
  input logic [NUM_FLAGS-1:0]     sm_set_i,
  input logic                     wr_en_i,
  input logic [ADDR_W-1:0]        wr_addr_i,
  input logic [NUM_FLAGS-1:0]     wr_data_i,
  input logic [NUM_FLAGS-1:0]     flags_o,
  input logic [RAW_W-1:0]         raw_o,
  input logic [NUM_OUT*RAW_W-1:0] masked_o,
  input logic [NUM_OUT-1:0]       irq_o
);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_OUT = ADDR_W'(2);

  p_vis_flags_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raw_o[RAW_W-1 -: NUM_VIS] == flags_o[NUM_VIS-1:0]);

  p_set_sticks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|sm_set_i) |=> ((flags_o & $past(sm_set_i)) == $past(sm_set_i)));

  p_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == A_CLR) |=>
      ((flags_o & $past(wr_data_i) & ~$past(sm_set_i)) == '0));

  p_force_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == A_SET) |=>
      ((flags_o & $past(wr_data_i)) == $past(wr_data_i)));

  p_flags_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(|sm_set_i) && !(wr_en_i && wr_addr_i < A_OUT)) |=> $stable(flags_o));

  p_fifo_level_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable({tx_not_full_i, rx_not_empty_i}) |-> $stable(raw_o[2*NUM_SM-1:0]));

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_chk
    p_irq_line_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (irq_o[k] == (|$past(masked_o[k*RAW_W +: RAW_W]))));
  end
endmodule

bind irq_agg_ctrl irq_agg_checker #(
  .NUM_SM   (NUM_SM),
  .NUM_FLAGS(NUM_FLAGS),
  .NUM_VIS  (NUM_VIS),
  .NUM_OUT  (NUM_OUT),
  .RAW_W    (RAW_W),
  .ADDR_W   (ADDR_W)
) u_irq_agg_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .rx_not_empty_i(rx_not_empty_i),
  .tx_not_full_i (tx_not_full_i),
  .sm_set_i      (sm_set_i),
  .wr_en_i       (wr_en_i),
  .wr_addr_i     (wr_addr_i),
  .wr_data_i     (wr_data_i[NUM_FLAGS-1:0]),
  .flags_o       (flags_o),
  .raw_o         (raw_o),
  .masked_o      (masked_o),
  .irq_o         (irq_o)
);

// File: tb/irq_agg_ctrl_bench.sv
`timescale 1ns/1ps
module irq_agg_ctrl_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  rx_not_empty_i = '0;
  logic [3:0]  tx_not_full_i = '0;
  logic [7:0]  sm_set_i = '0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [11:0] wr_data_i = '0;
  logic [7:0]  flags_o;
  logic [11:0] raw_o;
  logic [23:0] masked_o;
  logic [1:0]  irq_o;

  int total = 0;
  int bad = 0;

  always #4 clk_i = ~clk_i;

  irq_agg_ctrl u_irq_agg_ctrl (
    .clk_i, .rst_ni, .rx_not_empty_i, .tx_not_full_i, .sm_set_i,
    .wr_en_i, .wr_addr_i, .wr_data_i, .flags_o, .raw_o, .masked_o, .irq_o
  );

  typedef struct packed {
    logic        we;
    logic [2:0]  ad;
    logic [11:0] wd;
    logic [3:0]  rx;
    logic [3:0]  tx;
    logic [7:0]  st;
    logic [7:0]  ef;
    logic [11:0] er;
    logic [11:0] m0;
    logic [11:0] m1;
    logic [1:0]  iq;
  } step_t;

  localparam int NSTEP = 12;
  localparam step_t TBL [NSTEP] = '{
    '{1'b0, 3'd0, 12'h000, 4'h5, 4'h0, 8'h00, 8'h00, 12'h005, 12'h000, 12'h000, 2'b00},
    '{1'b1, 3'd2, 12'h00F, 4'h5, 4'h0, 8'h00, 8'h00, 12'h005, 12'h005, 12'h000, 2'b01},
    '{1'b0, 3'd0, 12'h000, 4'h0, 4'hA, 8'h21, 8'h21, 12'h1A0, 12'h000, 12'h000, 2'b00},
    '{1'b1, 3'd4, 12'hF00, 4'h0, 4'hA, 8'h00, 8'h21, 12'h1A0, 12'h000, 12'h100, 2'b10},
    '{1'b1, 3'd0, 12'hFFF, 4'h3, 4'hA, 8'h00, 8'h00, 12'h0A3, 12'h003, 12'h000, 2'b01},
    '{1'b1, 3'd1, 12'h00C, 4'h0, 4'h0, 8'h00, 8'h0C, 12'hC00, 12'h000, 12'hC00, 2'b10},
    '{1'b1, 3'd3, 12'h800, 4'h0, 4'h0, 8'h00, 8'h0C, 12'hC00, 12'h800, 12'hC00, 2'b11},
    '{1'b1, 3'd0, 12'h00C, 4'h0, 4'h0, 8'h04, 8'h04, 12'h400, 12'h800, 12'h400, 2'b11},
    '{1'b1, 3'd3, 12'h000, 4'h0, 4'h0, 8'h00, 8'h04, 12'h400, 12'h000, 12'h400, 2'b10},
    '{1'b1, 3'd0, 12'h004, 4'h0, 4'h0, 8'h00, 8'h00, 12'h000, 12'h000, 12'h000, 2'b00},
    '{1'b0, 3'd0, 12'h000, 4'h0, 4'h0, 8'hF0, 8'hF0, 12'h000, 12'h000, 12'h000, 2'b00},
    '{1'b1, 3'd5, 12'h001, 4'h0, 4'h0, 8'h00, 8'hF0, 12'h000, 12'h000, 12'h001, 2'b10}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [11:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R11: state during reset
    chk("R11 flags in reset", 32'(flags_o), 32'h0);
    chk("R11 masked in reset", 32'(masked_o), 32'h0);
    chk("R11 irq in reset", 32'(irq_o), 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NSTEP; i++) begin
      wr_en_i = TBL[i].we; wr_addr_i = TBL[i].ad; wr_data_i = TBL[i].wd;
      rx_not_empty_i = TBL[i].rx; tx_not_full_i = TBL[i].tx; sm_set_i = TBL[i].st;
      @(negedge clk_i);
      wr_en_i = 1'b0; sm_set_i = '0;
      @(negedge clk_i);
      chk($sformatf("R3/R4/R5/R6 flags step %0d", i), 32'(flags_o), 32'(TBL[i].ef));
      chk($sformatf("R1/R2/R9 raw step %0d", i), 32'(raw_o), 32'(TBL[i].er));
      chk($sformatf("R7/R8 line0 masked step %0d", i), 32'(masked_o[11:0]), 32'(TBL[i].m0));
      chk($sformatf("R7/R12 line1 masked step %0d", i), 32'(masked_o[23:12]), 32'(TBL[i].m1));
      chk($sformatf("R10 irq step %0d", i), 32'(irq_o), 32'(TBL[i].iq));
    end

    // R10: line lags masked status by one cycle
    wr(3'd5, 12'h000);
    @(negedge clk_i);
    wr_en_i = 1'b0;
    chk("R10 masked drops at once", 32'(masked_o[23:12]), 32'h0);
    chk("R10 irq still old value", 32'(irq_o), 32'h2);
    @(negedge clk_i);
    chk("R10 irq drops one cycle later", 32'(irq_o), 32'h0);

    // R4: zero bits in the clear mask leave flags alone
    wr(3'd0, 12'h030);
    @(negedge clk_i);
    wr_en_i = 1'b0;
    chk("R4 partial clear", 32'(flags_o), 32'hC0);

    // R8/R12: force on line 0 leaves flags and line 1 untouched
    wr(3'd3, 12'hFFF);
    @(negedge clk_i);
    wr_en_i = 1'b0;
    chk("R8 flags after line force", 32'(flags_o), 32'hC0);
    chk("R12 line1 after line0 force", 32'(masked_o[23:12]), 32'h0);
    chk("R7 line0 forced", 32'(masked_o[11:0]), 32'hFFF);

    // R11: reset in mid run
    rx_not_empty_i = 4'h0;
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R11 flags after mid reset", 32'(flags_o), 32'h0);
    chk("R11 masked after mid reset", 32'(masked_o), 32'h0);
    chk("R11 irq after mid reset", 32'(irq_o), 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule